// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block sequences maintenance work for a cache tag array. Software places a start address in one command register and an end address in its partner. Writing the end address launches a walk over every 32-byte line whose first byte address falls between the two addresses, both ends included. For each line the block sends one clean or invalidate request to the tag array. Clean ranges and invalidate ranges each have their own pair of start and end registers. The block also takes single-line clean, invalidate and clean-plus-invalidate commands, which act on the line that holds the given address.

The tag array sits behind a request/acknowledge port. Along with each acknowledge it returns whether the line was both valid and dirty. The array updates its own valid and dirty bits when it accepts a request. The engine raises a one-cycle writeback request when a cleaning operation meets a dirty line. A busy output stalls the requesting pipeline while work is in progress. A range whose start and end lie in different pages is refused and flagged. A single-line command that arrives during a walk can wait in a one-entry slot until the walk is finished.

Top module: `cache_range_maint`

## Requirements
- R1: A range walk sends exactly one tag request per line, in ascending line order, from the first line whose first byte is at or above the start address to the line that contains the end address. On `tag_op`, 0 means clean, 1 means invalidate and 2 means clean plus invalidate.
- R2: The `cmd_sel` codes are: 0 = clean-range start, 1 = clean-range end, 2 = invalidate-range start, 3 = invalidate-range end. An end write launches a walk using the start that was last written for the same kind, so a clean range gives op 0 and an invalidate range gives op 1.
- R3: `busy` goes high in the cycle after an accepted command that produces work. It stays high until the cycle after the acknowledge of the last queued line request.
- R4: While `tag_req` is high and not yet acknowledged, `tag_req`, `tag_line` and `tag_op` do not change.
- R5: If an end address lies in a different 4096-byte page from its start, `err` is set, no request is issued and `busy` stays low. The next accepted end write with both addresses in one page clears `err`.
- R6: A same-page range that contains no line first byte (the end is below the start, or both addresses sit inside one line past its first byte) completes at once: no request is issued, `busy` stays low and `err` is cleared.
- R7: `cmd_sel` codes 4, 5 and 6 issue one request with op 0, 1 or 2 respectively, for the line `cmd_addr[ADDR_W-1:5]`.
- R8: `wb_req` pulses for exactly one cycle, in the cycle after an acknowledge of op 0 or op 2 that came with `tag_dirty` high, and `wb_line` then holds that line. An invalidate acknowledge never raises `wb_req`.
- R9: A single-line command written while busy is held and is issued after the current walk, and `busy` stays high throughout. A further single-line command written while the slot is already full is dropped.
- R10: An end write made while the block is busy has no effect.
- R11: After reset, `busy`, `err`, `tag_req` and `wb_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command register write strobe |
| cmd_sel | input | 3 | Command register select code |
| cmd_addr | input | ADDR_W | Byte address written |
| busy | output | 1 | Stall to the requester while work is pending |
| err | output | 1 | Last end write crossed a page boundary |
| tag_req | output | 1 | Line maintenance request to the tag array |
| tag_op | output | 2 | Operation: 0 clean, 1 invalidate, 2 clean plus invalidate |
| tag_line | output | ADDR_W-5 | Line address of the request |
| tag_ack | input | 1 | Tag array accepts the request |
| tag_dirty | input | 1 | Line was valid and dirty, qualified by tag_ack |
| wb_req | output | 1 | One-cycle writeback request |
| wb_line | output | ADDR_W-5 | Line to write back |

## Verification
The hardest case to reach is a single-line command waiting in the hold slot while a walk is still running. A second command then arrives and must be dropped, and the held command must launch in the same cycle the walk retires. The stimulus gets there by slowing the tag array's acknowledges to one every few cycles, so that a long invalidate walk stays busy while two line commands are written back to back. The scoreboard then expects the held command as the only request after the walk, with its writeback, and expects `busy` to stay high across the handover.

// File: rtl/crm_pkg.sv
package crm_pkg;
   typedef enum logic [1:0] {
      OP_CLEAN     = 2'd0,
      OP_INV       = 2'd1,
      OP_CLEAN_INV = 2'd2
   } maint_op_e;
endpackage

// File: rtl/crm_front.sv
module crm_front
   import crm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int PAGE_BYTES = 4096,
   parameter bit HOLD_LINE  = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cmd_we,
   input  logic [2:0]                          cmd_sel,
   input  logic [ADDR_W-1:0]                   cmd_addr,
   input  logic                                walk_busy,
   output logic                                launch,
   output maint_op_e                           launch_op,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] launch_first,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] launch_last,
   output logic                                pend_valid,
   output logic                                err
);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int PG_SH  = $clog2(PAGE_BYTES);
   localparam int LINE_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] start_q [2];
   logic [ADDR_W-1:0] rs;
   logic [LINE_W:0]   first_l;
   logic [LINE_W-1:0] last_l, cmd_line;
   logic              is_start, is_end, is_line, idle, same_page, nonempty;
   logic              end_acc, range_go, direct_go, pend_go;
   logic [LINE_W-1:0] pend_line;
   maint_op_e         pend_op, line_op;

   assign is_start  = cmd_we && !cmd_sel[2] && !cmd_sel[0];
   assign is_end    = cmd_we && !cmd_sel[2] &&  cmd_sel[0];
   assign is_line   = cmd_we &&  cmd_sel[2] && (cmd_sel[1:0] != 2'b11);
   assign line_op   = maint_op_e'(cmd_sel[1:0]);
   assign cmd_line  = cmd_addr[ADDR_W-1:OFS_W];
   assign idle      = !walk_busy && !pend_valid;

   // range arithmetic: first line whose first byte is not below start
   assign rs        = start_q[cmd_sel[1]];
   assign same_page = rs[ADDR_W-1:PG_SH] == cmd_addr[ADDR_W-1:PG_SH];
   assign first_l   = {1'b0, rs[ADDR_W-1:OFS_W]} + {{LINE_W{1'b0}}, |rs[OFS_W-1:0]};
   assign last_l    = cmd_line;
   assign nonempty  = first_l <= {1'b0, last_l};
   assign end_acc   = is_end && idle;
   assign range_go  = end_acc && same_page && nonempty;
   assign direct_go = is_line && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q[0] <= '0;
         start_q[1] <= '0;
         err        <= 1'b0;
      end else begin
         if (is_start) start_q[cmd_sel[1]] <= cmd_addr;
         if (end_acc)  err <= !same_page;
      end
   end

   generate
      if (HOLD_LINE) begin : g_slot
         logic              pv;
         logic [LINE_W-1:0] pl;
         maint_op_e         po;
         logic              take;
         assign take = pv && !walk_busy;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pv <= 1'b0;
               pl <= '0;
               po <= OP_CLEAN;
            end else if (is_line && !idle && (!pv || take)) begin
               pv <= 1'b1;
               pl <= cmd_line;
               po <= line_op;
            end else if (take) begin
               pv <= 1'b0;
            end
         end
         assign pend_valid = pv;
         assign pend_go    = take;
         assign pend_line  = pl;
         assign pend_op    = po;
      end else begin : g_noslot
         assign pend_valid = 1'b0;
         assign pend_go    = 1'b0;
         assign pend_line  = '0;
         assign pend_op    = OP_CLEAN;
      end
   endgenerate

   assign launch = pend_go || range_go || direct_go;

   always_comb begin
      if (pend_go) begin
         launch_op    = pend_op;
         launch_first = pend_line;
         launch_last  = pend_line;
      end else if (range_go) begin
         launch_op    = cmd_sel[1] ? OP_INV : OP_CLEAN;
         launch_first = first_l[LINE_W-1:0];
         launch_last  = last_l;
      end else begin
         launch_op    = line_op;
         launch_first = cmd_line;
         launch_last  = cmd_line;
      end
   end

   // R5: the error flag only rises after an end-register write
   a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(cmd_we && !cmd_sel[2] && cmd_sel[0]));
   // R10: nothing is handed to the walker while it is running
   a_r10_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !walk_busy);
   // R9: a held command stays held while the walk continues
   a_r9_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && walk_busy) |=> pend_valid);
endmodule

// File: rtl/crm_walker.sv
module crm_walker
   import crm_pkg::*;
#(
   parameter int LINE_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  maint_op_e         launch_op,
   input  logic [LINE_W-1:0] launch_first,
   input  logic [LINE_W-1:0] launch_last,
   output logic              busy,
   output logic              tag_req,
   output maint_op_e         tag_op,
   output logic [LINE_W-1:0] tag_line,
   input  logic              tag_ack,
   input  logic              tag_dirty,
   output logic              wb_req,
   output logic [LINE_W-1:0] wb_line
);
   logic              active;
   logic [LINE_W-1:0] cur, last;
   maint_op_e         op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cur     <= '0;
         last    <= '0;
         op      <= OP_CLEAN;
         wb_req  <= 1'b0;
         wb_line <= '0;
      end else begin
         wb_req <= active && tag_ack && (op != OP_INV) && tag_dirty;
         if (active && tag_ack) wb_line <= cur;
         if (!active) begin
            if (launch) begin
               active <= 1'b1;
               cur    <= launch_first;
               last   <= launch_last;
               op     <= launch_op;
            end
         end else if (tag_ack) begin
            if (cur == last) active <= 1'b0;
            else             cur    <= cur + 1'b1;
         end
      end
   end

   assign busy     = active;
   assign tag_req  = active;
   assign tag_op   = op;
   assign tag_line = cur;

   // R4: an outstanding request holds steady until accepted
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_req && !tag_ack) |=> (tag_req && $stable(tag_line) && $stable(tag_op)));
   // R1: lines are visited in ascending order
   a_r1_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_req && tag_ack && (cur != last)) |=> (tag_req && tag_line == $past(tag_line) + 1'b1));
   // R8: an invalidate acknowledge never produces a writeback
   a_r8_no_wb_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_req && tag_ack && tag_op == OP_INV) |=> !wb_req);
   // R8: the writeback pulse lasts a single cycle per acknowledge
   a_r8_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> $past(tag_req && tag_ack));
endmodule

// File: rtl/cache_range_maint.sv
module cache_range_maint
   import crm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int PAGE_BYTES = 4096,
   parameter bit HOLD_LINE  = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cmd_we,
   input  logic [2:0]                           cmd_sel,
   input  logic [ADDR_W-1:0]                    cmd_addr,
   output logic                                 busy,
   output logic                                 err,
   output logic                                 tag_req,
   output logic [1:0]                           tag_op,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] tag_line,
   input  logic                                 tag_ack,
   input  logic                                 tag_dirty,
   output logic                                 wb_req,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wb_line
);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFS_W;

   generate
      if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 2)
         $error("LINE_BYTES must be a power of two");
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES <= LINE_BYTES)
         $error("PAGE_BYTES must be a power of two above LINE_BYTES");
      if (ADDR_W <= $clog2(PAGE_BYTES))
         $error("ADDR_W must exceed the page offset width");
   endgenerate

   logic              launch, walk_busy, pend_valid;
   maint_op_e         launch_op, op_e;
   logic [LINE_W-1:0] launch_first, launch_last;

   crm_front #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
      .PAGE_BYTES(PAGE_BYTES), .HOLD_LINE(HOLD_LINE)
   ) u_front (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
      .cmd_addr(cmd_addr), .walk_busy(walk_busy), .launch(launch),
      .launch_op(launch_op), .launch_first(launch_first),
      .launch_last(launch_last), .pend_valid(pend_valid), .err(err)
   );

   crm_walker #(.LINE_W(LINE_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
      .launch_first(launch_first), .launch_last(launch_last),
      .busy(walk_busy), .tag_req(tag_req), .tag_op(op_e),
      .tag_line(tag_line), .tag_ack(tag_ack), .tag_dirty(tag_dirty),
      .wb_req(wb_req), .wb_line(wb_line)
   );

   assign tag_op = op_e;
   assign busy   = walk_busy || pend_valid;

   // R3: the stall covers every moment a request is outstanding
   a_r3_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req |-> busy);
endmodule

// File: tb/sim_cache_range_maint.sv
module sim_cache_range_maint;
   localparam int AW = 32;
   localparam int LW = 27;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [2:0]    cmd_sel = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic          busy, err, tag_req, wb_req;
   logic [1:0]    tag_op;
   logic [LW-1:0] tag_line, wb_line;
   logic          tag_ack = 1'b0;
   logic          tag_dirty = 1'b0;

   always #2.5 clk = ~clk;

   cache_range_maint u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_sel(cmd_sel),
      .cmd_addr(cmd_addr), .busy(busy), .err(err), .tag_req(tag_req),
      .tag_op(tag_op), .tag_line(tag_line), .tag_ack(tag_ack),
      .tag_dirty(tag_dirty), .wb_req(wb_req), .wb_line(wb_line)
   );

   int checks = 0;
   int fails  = 0;
   int ack_gap = 0;
   int wait_cnt = 0;
   bit finished = 1'b0;

   logic [1:0]    q_op[$];
   logic [LW-1:0] q_line[$];
   bit            mvalid [256];
   bit            mdirty [256];
   logic [1:0]    hs_op;
   logic [LW-1:0] hs_line;
   bit            hs_dirty;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor and tag-array model
   always @(negedge clk) begin
      if (!rst_n) begin
         tag_ack  = 1'b0;
         wait_cnt = 0;
      end else begin
         if (tag_ack) begin
            tag_ack = 1'b0;
            if (q_op.size() == 0) begin
               chk(1'b0, "R1 unexpected request", {hs_op, hs_line}, 0);
            end else begin
               logic [1:0]    eop;
               logic [LW-1:0] eln;
               bit            ewb;
               eop = q_op.pop_front();
               eln = q_line.pop_front();
               chk(hs_op == eop && hs_line == eln, "R1/R4 request", {hs_op, hs_line}, {eop, eln});
               ewb = (hs_op != 2'd1) && hs_dirty;
               chk(wb_req == ewb && (!ewb || wb_line == hs_line), "R8 writeback",
                   {wb_req, wb_line}, {ewb, hs_line});
               chk(busy == (q_op.size() != 0), "R3 busy after ack", busy, q_op.size() != 0);
            end
            if (hs_op != 2'd1) mdirty[hs_line[7:0]] = 1'b0;
            if (hs_op != 2'd0) begin
               mvalid[hs_line[7:0]] = 1'b0;
               mdirty[hs_line[7:0]] = 1'b0;
            end
         end else if (wb_req) begin
            chk(1'b0, "R8 spurious writeback", wb_req, 0);
         end
         if (tag_req) begin
            if (wait_cnt >= ack_gap) begin
               hs_op     = tag_op;
               hs_line   = tag_line;
               hs_dirty  = mvalid[tag_line[7:0]] && mdirty[tag_line[7:0]];
               tag_dirty = hs_dirty;
               tag_ack   = 1'b1;
               wait_cnt  = 0;
            end else begin
               wait_cnt++;
            end
         end
      end
   end

   task automatic wr(input logic [2:0] sel, input logic [AW-1:0] a);
      @(negedge clk);
      cmd_we = 1'b1; cmd_sel = sel; cmd_addr = a;
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic push(input logic [1:0] op, input logic [LW-1:0] ln);
      q_op.push_back(op);
      q_line.push_back(ln);
   endtask

   task automatic preset(input logic [LW-1:0] ln, input bit v, input bit d);
      mvalid[ln[7:0]] = v;
      mdirty[ln[7:0]] = d;
   endtask

   // driver: predicts the walk, then writes start and end
   task automatic range_op(input bit inv, input logic [AW-1:0] s, input logic [AW-1:0] e, input string req);
      longint first, last;
      bit work;
      first = (longint'(s) + 31) >> 5;
      last  = longint'(e) >> 5;
      work  = ((s >> 12) == (e >> 12)) && (first <= last);
      if (work) for (longint l = first; l <= last; l++) push(inv ? 2'd1 : 2'd0, LW'(l));
      wr(inv ? 3'd2 : 3'd0, s);
      wr(inv ? 3'd3 : 3'd1, e);
      chk(busy == work, {req, " busy after end write"}, busy, work);
   endtask

   task automatic line_op(input logic [2:0] sel, input logic [AW-1:0] a, input bit expect_push);
      if (expect_push) push(sel[1:0], a[AW-1:5]);
      wr(sel, a);
   endtask

   task automatic settle(input string req);
      int n = 0;
      while (busy && n < 2000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
      chk(q_op.size() == 0, {req, " all expected requests seen"}, q_op.size(), 0);
      chk(!tag_req && !busy, {req, " idle"}, {tag_req, busy}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin mvalid[i] = 1'b0; mdirty[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({busy, err, tag_req, wb_req} == 4'b0, "R11 reset", {busy, err, tag_req, wb_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R8: clean range with some dirty lines, immediate acks
      for (int l = 'h80; l <= 'h87; l++) preset(LW'(l), 1'b1, l[0]);
      ack_gap = 0;
      range_op(1'b0, 32'h1000, 32'h10E0, "R2 clean");
      settle("R1 clean range");

      // R4 R8: invalidate range on dirty lines, slow acks, no writeback
      for (int l = 'h102; l <= 'h108; l++) preset(LW'(l), 1'b1, 1'b1);
      ack_gap = 2;
      range_op(1'b1, 32'h2040, 32'h2100, "R4 inv");
      settle("R8 inv range");

      // R1: unaligned start skips the line whose first byte is below start
      ack_gap = 1;
      range_op(1'b0, 32'h3010, 32'h305F, "R1 unaligned");
      settle("R1 unaligned");

      // R6: both addresses inside one line past its first byte
      range_op(1'b0, 32'h3010, 32'h301F, "R6 inside line");
      settle("R6 inside line");

      // R5: page crossing is refused
      range_op(1'b1, 32'h4FE0, 32'h5000, "R5 cross page");
      chk(err == 1'b1, "R5 err set", err, 1);
      settle("R5 cross page");
      range_op(1'b1, 32'h4F00, 32'h4F20, "R5 recover");
      chk(err == 1'b0, "R5 err cleared", err, 0);
      settle("R5 recover");

      // R6: end below start
      range_op(1'b0, 32'h6100, 32'h6000, "R6 reversed");
      chk(err == 1'b0, "R6 err clear", err, 0);
      settle("R6 reversed");

      // R2: independent start registers per kind
      push(2'd0, 27'h380); push(2'd0, 27'h381);
      wr(3'd0, 32'h7000);
      wr(3'd2, 32'h7800);
      wr(3'd1, 32'h7020);
      settle("R2 separate pairs");

      // R7 R8: single-line commands
      preset(27'h3A0, 1'b1, 1'b1);
      preset(27'h3A1, 1'b1, 1'b1);
      preset(27'h3A2, 1'b1, 1'b1);
      line_op(3'd4, 32'h7404, 1'b1);
      chk(busy == 1'b1, "R3 busy after line command", busy, 1);
      settle("R7 line clean");
      line_op(3'd5, 32'h743C, 1'b1);
      settle("R7 line inv");
      line_op(3'd6, 32'h7440, 1'b1);
      settle("R7 line clean+inv");

      // R9: hold one line command during a slow walk, drop the second
      ack_gap = 3;
      preset(27'h480, 1'b1, 1'b1);
      range_op(1'b1, 32'h8000, 32'h80E0, "R9 walk");
      line_op(3'd4, 32'h9000, 1'b1);
      line_op(3'd5, 32'h9100, 1'b0);
      chk(busy == 1'b1, "R9 busy while held", busy, 1);
      settle("R9 held command");

      // R10: end write during a walk is ignored
      ack_gap = 2;
      range_op(1'b0, 32'hA000, 32'hA0E0, "R10 walk");
      wr(3'd2, 32'hA000);
      wr(3'd3, 32'hA040);
      settle("R10 ignored end write");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule